// File: doc/BRIEF.md
# Multichannel SPI Master Controller

This block is a register-mapped SPI master that serves up to four chip-select channels from one shared serial engine. Software fills in each channel's configuration register and then sets the channel's enable bit. The configuration sets clock polarity and phase, chip-select polarity, word length, a power-of-two SCLK divider, the transfer mode and a manual chip-select hold bit. Software then moves words through the channel's transmit and receive registers and polls the status register. When several channels are enabled at once, only the lowest-numbered enabled channel owns the engine and its chip-select line.

The serial engine is a four-state machine. It leaves IDLE for LEAD when a word is started. LEAD is the half period before the leading SCLK edge, and it moves to TRAIL on a half-period tick. TRAIL is the half period before the trailing edge. On a tick it returns to LEAD while bits remain, or goes to DONE after the last bit. DONE lasts one cycle, hands over the received word and returns to IDLE. The receive-only mode re-arms the engine from IDLE with no further transmit write. A soft reset written over the bus clears every register and shows completion through a reset-done flag.

Top module: `spim_ctrl`

## Requirements
- R1: Channel n has its registers at byte address 0x2C + 0x14*n, in the order configuration (+0x0), status (+0x4), control (+0x8), transmit (+0xC) and receive (+0x10). Configuration reads back only its implemented bits [13:0] and [20] (mask 0x00103FFF). Control bit 0 reads back as written.
- R2: After reset, every channel's status reads 0b110, with receive-full (bit 0) clear, transmit-empty (bit 1) set and end-of-transfer (bit 2) set. All chip selects sit at their inactive level, SCLK is 0, and the reset-done register at 0x14 reads 1.
- R3: In full-duplex mode (configuration bits [13:12] = 0), a write to the transmit register sends configuration[11:7]+1 bits MSB first. The bits sampled on MISO form the receive word, right-aligned, and receive-full is set.
- R4: Configuration bit 0 is clock phase and bit 1 is clock polarity. SCLK idles at the polarity level. With MISO looped to MOSI, all four modes return the transmitted word.
- R5: With divider field configuration[5:2] = D, the SCLK period is 2^(D+1) clock cycles. Any D above 12 acts as 12.
- R6: When configuration bit 6 is set the chip select is active low, and when it is clear it is active high. A channel that is not asserted drives the inactive level.
- R7: While configuration bit 20 is set on the active channel, its chip select stays asserted across consecutive words and between them. Clearing the bit releases it. The chip select is also asserted while a word is shifting.
- R8: In transmit-only mode (configuration bits [13:12] = 2), received bits are discarded and receive-full never sets. End-of-transfer reads 1 once the engine is idle and transmit-empty is set.
- R9: In receive-only mode (configuration bits [13:12] = 1), one transmit write starts words that repeat back to back with no further writes. MOSI is held at 0 and each word sets receive-full.
- R10: Reading the receive register clears receive-full. A word that completes while receive-full is still set overwrites the held word.
- R11: Writing 1 to bit 1 at address 0x10 returns every register to its reset value. The reset-done bit (bit 0 at 0x14) reads 0 right after the write and reads 1 two cycles after the write edge.
- R12: Control bit 0 enables a channel, and the lowest-numbered enabled channel is the active one. Only the active channel can assert its chip select; every other line stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip select per channel, polarity per channel |

## Verification
The hardest state to reach is a receive-only stream. Once a single write has armed it, the engine keeps restarting itself, so the bench holds MISO high and disables MOSI checking only after it has collected two full words with no intervening write. A watcher records any high level on MOSI during that window. Forced chip select is checked the same way: a monitor samples the line on every cycle across two transmit-only words and the polling gap between them. The divider clamp is reached by writing an exponent of 15 and measuring the spacing between SCLK rising edges.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam logic [1:0] TRM_DUPLEX = 2'd0;
    localparam logic [1:0] TRM_RXONLY = 2'd1;
    localparam logic [1:0] TRM_TXONLY = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } eng_st_e;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int DIV_W   = 4,
    parameter int MAX_EXP = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] exp_sel,
    output logic             tick
);
    localparam int CNT_W = MAX_EXP + 1;

    logic [DIV_W-1:0] eff;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        eff  = (exp_sel > DIV_W'(MAX_EXP)) ? DIV_W'(MAX_EXP) : exp_sel;
        lim  = (CNT_W'(1) << eff) - CNT_W'(1);
        tick = run && (cnt == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr || !run || tick) cnt <= '0;
        else                    cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 4,
    parameter int MAX_EXP = 12,
    parameter int WL_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              cpol_live,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  clkd,
    input  logic [WL_W-1:0]   wl,
    input  logic [DATA_W-1:0] txword,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              word_done,
    output logic [DATA_W-1:0] rxword
);
    eng_st_e           state, nxt;
    logic [DATA_W-1:0] sh;
    logic [WL_W-1:0]   bitcnt;
    logic              rb, mo, sclk_r, cpol_q, cpha_q;
    logic [DIV_W-1:0]  clkd_q;
    logic              tick, run;

    assign run = (state == ST_LEAD) || (state == ST_TRAIL);

    spim_clkdiv #(.DIV_W(DIV_W), .MAX_EXP(MAX_EXP)) div_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
        .exp_sel(clkd_q), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = (bitcnt == '0) ? ST_DONE : ST_LEAD;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            sh <= '0; bitcnt <= '0; rb <= 1'b0; mo <= 1'b0;
            sclk_r <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; clkd_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    sh     <= txword << (WL_W'(DATA_W - 1) - wl);
                    bitcnt <= wl;
                    cpol_q <= cpol;
                    cpha_q <= cpha;
                    clkd_q <= clkd;
                    sclk_r <= cpol;
                    mo     <= 1'b0;
                end
                ST_LEAD: if (tick) begin
                    sclk_r <= ~cpol_q;
                    if (!cpha_q) rb <= miso;
                    mo <= sh[DATA_W-1];
                end
                ST_TRAIL: if (tick) begin
                    sclk_r <= cpol_q;
                    sh     <= {sh[DATA_W-2:0], cpha_q ? miso : rb};
                    bitcnt <= bitcnt - 1'b1;
                end
                ST_DONE: ;
            endcase
        end
    end

    always_comb begin
        sclk      = (state == ST_IDLE) ? cpol_live : sclk_r;
        mosi      = run ? (cpha_q ? mo : sh[DATA_W-1]) : 1'b0;
        busy      = (state != ST_IDLE);
        word_done = (state == ST_DONE);
        rxword    = sh;
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
        word_done |=> !word_done);

    assert_sclk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (run && !tick) |=> $stable(sclk));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int ADDR_W  = 8,
    parameter int REG_W   = 32,
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 4,
    parameter int MAX_EXP = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCH-1:0]    spi_cs
);
    localparam int IDXW      = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WL_W      = $clog2(DATA_W);
    localparam int CH_BASE   = 'h2C;
    localparam int CH_STRIDE = 'h14;
    localparam int SYS_CFG   = 'h10;
    localparam int SYS_STAT  = 'h14;
    localparam logic [REG_W-1:0] CFG_MASK = REG_W'(32'h0010_3FFF);

    function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int slot);
        return ADDR_W'(CH_BASE + CH_STRIDE * ch + 4 * slot);
    endfunction

    logic [REG_W-1:0]  cfg  [NCH];
    logic [DATA_W-1:0] tx_q [NCH];
    logic [DATA_W-1:0] rx_q [NCH];
    logic [NCH-1:0]    en, txs, rxs, eot, cs_on;
    logic              rx_run;
    logic [IDXW-1:0]   cur_ch, act;
    logic [1:0]        cur_trm, act_trm;
    logic [1:0]        rst_cnt;
    logic              have_act, start, srst_wr, sw_clr, rdone;
    logic              eng_busy, word_done;
    logic [DATA_W-1:0] rxword;

    assign srst_wr = bus_wr && (bus_addr == ADDR_W'(SYS_CFG)) && bus_wdata[1];
    assign sw_clr  = srst_wr || (rst_cnt != 2'd0);
    assign rdone   = (rst_cnt == 2'd0);

    always_comb begin
        act = '0; have_act = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (en[i]) begin act = IDXW'(i); have_act = 1'b1; end
        end
        act_trm = cfg[act][13:12];
        start = have_act && !eng_busy && !sw_clr &&
                (((act_trm != TRM_RXONLY) && !txs[act]) ||
                 ((act_trm == TRM_RXONLY) && (!txs[act] || rx_run)));
    end

    spim_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .MAX_EXP(MAX_EXP), .WL_W(WL_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .clr(sw_clr), .start(start),
        .cpol_live(have_act && cfg[act][1]),
        .cpol(cfg[act][1]), .cpha(cfg[act][0]), .clkd(cfg[act][5:2]),
        .wl(cfg[act][7 +: WL_W]),
        .txword((act_trm == TRM_RXONLY) ? '0 : tx_q[act]),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .busy(eng_busy), .word_done(word_done), .rxword(rxword)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rst_cnt <= 2'd0;
        else if (srst_wr) rst_cnt <= 2'd2;
        else if (rst_cnt != 2'd0) rst_cnt <= rst_cnt - 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                cfg[i] <= '0; tx_q[i] <= '0; rx_q[i] <= '0;
                en[i] <= 1'b0; txs[i] <= 1'b1; rxs[i] <= 1'b0;
            end
            rx_run <= 1'b0; cur_ch <= '0; cur_trm <= TRM_DUPLEX;
        end else if (srst_wr) begin
            for (int i = 0; i < NCH; i++) begin
                cfg[i] <= '0; tx_q[i] <= '0; rx_q[i] <= '0;
                en[i] <= 1'b0; txs[i] <= 1'b1; rxs[i] <= 1'b0;
            end
            rx_run <= 1'b0; cur_ch <= '0; cur_trm <= TRM_DUPLEX;
        end else begin
            if (start) begin
                cur_ch  <= act;
                cur_trm <= act_trm;
                if (act_trm == TRM_RXONLY) rx_run <= 1'b1;
            end else if (!(have_act && act_trm == TRM_RXONLY)) begin
                rx_run <= 1'b0;
            end
            for (int i = 0; i < NCH; i++) begin
                if (start && act == IDXW'(i)) txs[i] <= 1'b1;
                if (bus_rd && bus_addr == reg_addr(i, 4)) rxs[i] <= 1'b0;
                if (word_done && cur_ch == IDXW'(i) && cur_trm != TRM_TXONLY) begin
                    rx_q[i] <= rxword;
                    rxs[i]  <= 1'b1;
                end
                if (bus_wr && bus_addr == reg_addr(i, 0)) cfg[i] <= bus_wdata & CFG_MASK;
                if (bus_wr && bus_addr == reg_addr(i, 2)) en[i] <= bus_wdata[0];
                if (bus_wr && bus_addr == reg_addr(i, 3)) begin
                    tx_q[i] <= bus_wdata[DATA_W-1:0];
                    txs[i]  <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            eot[i]   = txs[i] && !(eng_busy && cur_ch == IDXW'(i)) && !(start && act == IDXW'(i));
            cs_on[i] = eng_busy ? (cur_ch == IDXW'(i))
                                : (have_act && act == IDXW'(i) && cfg[i][20]);
            spi_cs[i] = cs_on[i] ^ cfg[i][6];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(SYS_STAT)) bus_rdata = REG_W'(rdone);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == reg_addr(i, 0)) bus_rdata = cfg[i];
            if (bus_addr == reg_addr(i, 1)) bus_rdata = REG_W'({eot[i], txs[i], rxs[i]});
            if (bus_addr == reg_addr(i, 2)) bus_rdata = REG_W'(en[i]);
            if (bus_addr == reg_addr(i, 4)) bus_rdata = REG_W'(rx_q[i]);
        end
    end

    assert_cs_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_on));

    assert_rdone_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> !rdone);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_txonly_norx_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!rxs[g] && cur_ch == IDXW'(g) && cur_trm == TRM_TXONLY && !srst_wr) |=> !rxs[g]);
    end
endmodule

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;
    logic        loop_en = 1'b1, miso_drv = 1'b0;
    logic        mon_en = 1'b0, mosi_hi = 1'b0, cs_mon = 1'b0, cs_drop = 1'b0;
    int          checks = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;
    assign spi_miso = loop_en ? spi_mosi : miso_drv;

    spim_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (mon_en && spi_mosi) mosi_hi <= 1'b1;
        if (cs_mon && spi_cs[0] !== 1'b0) cs_drop <= 1'b1;
    end

    // {cpol, cpha, wl[4:0], clkd[3:0], data[31:0]}
    localparam logic [42:0] VEC [8] = '{
        {1'b0, 1'b0, 5'd7,  4'd0, 32'h0000_00A5},
        {1'b0, 1'b1, 5'd7,  4'd1, 32'h0000_003C},
        {1'b1, 1'b0, 5'd15, 4'd0, 32'h0000_BEEF},
        {1'b1, 1'b1, 5'd15, 4'd2, 32'h0000_1234},
        {1'b0, 1'b0, 5'd31, 4'd0, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 5'd0,  4'd0, 32'h0000_0001},
        {1'b0, 1'b1, 5'd4,  4'd1, 32'h0000_0015},
        {1'b1, 1'b0, 5'd11, 4'd0, 32'h0000_F0A5}
    };

    function automatic logic [7:0] a_reg(input int ch, input int slot);
        return 8'(8'h2C + 8'h14 * ch + 4 * slot);
    endfunction

    function automatic logic [31:0] mkcfg(input logic cpol, cpha, input logic [3:0] clkd,
                                          input logic [4:0] wl, input logic [1:0] trm,
                                          input logic epol, force_cs);
        return (32'(force_cs) << 20) | (32'(trm) << 12) | (32'(wl) << 7) |
               (32'(epol) << 6) | (32'(clkd) << 2) | (32'(cpol) << 1) | 32'(cpha);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_bit(input int ch, input int b);
        logic [31:0] v;
        for (int n = 0; n < 40000; n++) begin
            rd(a_reg(ch, 1), v);
            if (v[b]) break;
        end
    endtask

    task automatic measure(input logic [3:0] clkd, input int exp_p, input string tag);
        int t1, t2;
        wr(a_reg(0, 0), mkcfg(1'b0, 1'b0, clkd, 5'd1, 2'd0, 1'b1, 1'b0));
        wr(a_reg(0, 3), 32'h2);
        @(posedge spi_sclk); t1 = cyc;
        @(posedge spi_sclk); t2 = cyc;
        chk(32'(t2 - t1), 32'(exp_p), tag);
        @(negedge clk);
        wait_bit(0, 2);
    endtask

    initial begin
        wait (cyc == 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] msk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(a_reg(0, 1), v); chk(v, 32'h6, "R2 status after reset");
        chk(32'(spi_cs), 32'h0, "R2 chip selects inactive");
        rd(8'h14, v); chk(v, 32'h1, "R2 reset-done");
        chk(32'(spi_sclk), 32'h0, "R2 sclk idle");

        // R1 map and readback
        wr(a_reg(1, 0), 32'hFFFF_FFFF);
        rd(a_reg(1, 0), v); chk(v, 32'h0010_3FFF, "R1 cfg readback mask");
        wr(a_reg(1, 0), 32'h0);
        wr(a_reg(3, 2), 32'h1);
        rd(a_reg(3, 2), v); chk(v, 32'h1, "R1 ctrl readback ch3");
        wr(a_reg(3, 2), 32'h0);

        // R3/R4/R10 table of full-duplex loopback words
        wr(a_reg(0, 2), 32'h1);
        foreach (VEC[k]) begin
            wr(a_reg(0, 0), mkcfg(VEC[k][42], VEC[k][41], VEC[k][35:32], VEC[k][40:36],
                                  2'd0, 1'b1, 1'b0));
            wr(a_reg(0, 3), VEC[k][31:0]);
            wait_bit(0, 2);
            msk = (64'd1 << (VEC[k][40:36] + 1)) - 64'd1;
            rd(a_reg(0, 1), v); chk(32'(v[0]), 32'h1, "R3 rx-full after word");
            rd(a_reg(0, 4), v); chk(v, VEC[k][31:0] & msk[31:0], "R4 loopback word");
            rd(a_reg(0, 1), v); chk(32'(v[0]), 32'h0, "R10 rx-full cleared by read");
        end

        // R4 idle level follows polarity
        wr(a_reg(0, 0), mkcfg(1'b1, 1'b0, 4'd0, 5'd7, 2'd0, 1'b1, 1'b0));
        chk(32'(spi_sclk), 32'h1, "R4 sclk idles high");
        wr(a_reg(0, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd0, 1'b1, 1'b0));
        chk(32'(spi_sclk), 32'h0, "R4 sclk idles low");

        // R10 overwrite
        wr(a_reg(0, 3), 32'h11); wait_bit(0, 2);
        wr(a_reg(0, 3), 32'h22); wait_bit(0, 2);
        rd(a_reg(0, 4), v); chk(v, 32'h22, "R10 overwrite keeps newest");

        // R8 transmit-only
        wr(a_reg(0, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd2, 1'b1, 1'b0));
        wr(a_reg(0, 3), 32'h5A); wait_bit(0, 2);
        rd(a_reg(0, 1), v); chk(v, 32'h6, "R8 tx-only status");

        // R6/R7 chip-select polarity and forced hold
        wr(a_reg(1, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd0, 1'b1, 1'b0));
        wr(a_reg(0, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd2, 1'b1, 1'b1));
        chk(32'(spi_cs), 32'h2, "R6 active-low forced select");
        cs_mon = 1'b1;
        wr(a_reg(0, 3), 32'h81); wait_bit(0, 2);
        wr(a_reg(0, 3), 32'h7E); wait_bit(0, 2);
        cs_mon = 1'b0;
        chk(32'(cs_drop), 32'h0, "R7 select held across words");
        wr(a_reg(0, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd2, 1'b1, 1'b0));
        chk(32'(spi_cs), 32'h3, "R7 select released");

        // R12 channel priority
        wr(a_reg(2, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd2, 1'b0, 1'b1));
        wr(a_reg(2, 2), 32'h1);
        chk(32'(spi_cs), 32'h3, "R12 lower channel owns select");
        wr(a_reg(0, 2), 32'h0);
        chk(32'(spi_cs), 32'h7, "R12 ch2 active after ch0 disabled");
        wr(a_reg(2, 2), 32'h0);
        wr(a_reg(2, 0), 32'h0);
        wr(a_reg(0, 2), 32'h1);

        // R9 receive-only stream
        loop_en = 1'b0; miso_drv = 1'b1;
        wr(a_reg(0, 0), mkcfg(1'b0, 1'b0, 4'd0, 5'd7, 2'd1, 1'b1, 1'b1));
        mosi_hi = 1'b0; mon_en = 1'b1;
        wr(a_reg(0, 3), 32'hAA);
        wait_bit(0, 0);
        rd(a_reg(0, 4), v); chk(v, 32'hFF, "R9 first rx-only word");
        wait_bit(0, 0);
        rd(a_reg(0, 4), v); chk(v, 32'hFF, "R9 second word without write");
        mon_en = 1'b0;
        chk(32'(mosi_hi), 32'h0, "R9 mosi held low");
        wr(a_reg(0, 2), 32'h0);
        repeat (60) @(negedge clk);
        rd(a_reg(0, 4), v);
        loop_en = 1'b1;

        // R5 divider
        wr(a_reg(0, 2), 32'h1);
        measure(4'd0, 2, "R5 period divider 0");
        measure(4'd3, 16, "R5 period divider 3");
        measure(4'd15, 8192, "R5 period clamped divider");

        // R11 soft reset
        wr(8'h10, 32'h2);
        rd(8'h14, v); chk(v, 32'h0, "R11 reset-done low after write");
        rd(8'h14, v); chk(v, 32'h0, "R11 reset-done low one cycle later");
        rd(8'h14, v); chk(v, 32'h1, "R11 reset-done high two cycles later");
        rd(a_reg(0, 0), v); chk(v, 32'h0, "R11 cfg cleared");
        rd(a_reg(0, 2), v); chk(v, 32'h0, "R11 ctrl cleared");
        rd(a_reg(0, 1), v); chk(v, 32'h6, "R11 status default");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule